// File: doc/BRIEF.md
# IO Rail Deep Power-Down Controller

This block puts groups of IO rails into deep power-down, or brings them back out, on command from a register bus. Software writes a request word that carries a two-bit command in its top bits and a bitmap of rails in the remaining thirty bits. The controller waits a programmable number of bus clock cycles so the pads can settle. It then updates the per-rail power-down outputs and the status words that software polls.

The sixty rails are split over two banks of thirty. Each bank has its own request word and its own status word. A request that arrives while another is settling is parked in a one-entry holding slot and runs as soon as the current one finishes. Status only moves at the end of a settle, and only while the sampling switch is on.

Top module: `io_dpd_ctrl`

## Requirements
- R1: After reset, every rail output and every status bit is 0 (rail powered). The sampling switch and the settle-time register read 0, and `busy` is 0.
- R2: A request with command 2 (power down) sets the selected status bits and rail outputs to 1 when its settle ends. Unselected rails keep their value.
- R3: A request with command 1 (power up) clears the selected status bits and rail outputs to 0 when its settle ends. Unselected rails keep their value.
- R4: Request bit b of the word at 0x1B8 controls `rail_dpd[b]`, and status bit b at 0x1BC reports it. Request bit b at 0x1C0 controls `rail_dpd[30+b]`, and status bit b at 0x1C4 reports it. The command sits in request bits [31:30] and is never a rail select.
- R5: With settle value T in the register at 0x1C8, the rail change appears on the clock edge T+1 cycles after the edge that accepts the write. `busy` is 1 from the accepting edge until then, and outputs do not change at any other time.
- R6: When bit 0 of the sampling register at 0x020 is 0 at the end of a settle, the request finishes with no change to status or rail outputs.
- R7: Commands 0 and 3 start no settle, leave `busy` at 0 and change no rail.
- R8: A valid request written while `busy` is 1 is held. It starts on the cycle after the current settle ends, so both requests take effect in order.
- R9: The sampling bit, the settle value and the last written request word of each bank read back as written. Status reads return 0 in bits [31:30].
- R10: Writes to offsets outside the register set change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational while selected |
| rail_dpd | output | 60 | Per-rail power-down drive, 1 = powered down |
| busy | output | 1 | A settle is running or a request is held |

## Verification
The case hardest to reach from the ports is a second request landing in the holding slot while a settle is still counting. The first request must be visibly applied while the second has not yet touched its rail. The stimulus issues two back-to-back bus writes against a settle of three cycles, so the second write is accepted mid-count. It then samples the rail outputs on the exact edge where the first settle ends and again after `busy` falls. Turning sampling off before a request exercises the other hidden path: a settle that runs to its end and then discards its result.

// File: rtl/io_dpd_pkg.sv
package io_dpd_pkg;
  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 32;
  localparam int BANK_W      = 30;
  localparam int N_BANKS     = 2;
  localparam int BANK_IDX_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
  localparam int N_RAILS     = N_BANKS * BANK_W;
  localparam int BANK_STRIDE = 8;

  localparam logic [ADDR_W-1:0] OFS_SAMPLE = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_REQ0   = 12'h1B8;
  localparam logic [ADDR_W-1:0] OFS_TIMING = 12'h1C8;

  typedef enum logic [1:0] {
    CMD_IDLE     = 2'd0,
    CMD_RAIL_ON  = 2'd1,
    CMD_RAIL_OFF = 2'd2,
    CMD_RSVD     = 2'd3
  } dpd_cmd_e;

  typedef struct packed {
    logic [BANK_IDX_W-1:0] bank;
    dpd_cmd_e              cmd;
    logic [BANK_W-1:0]     sel;
  } dpd_req_t;

  function automatic logic [ADDR_W-1:0] req_ofs(input int b);
    return OFS_REQ0 + ADDR_W'(b * BANK_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] stat_ofs(input int b);
    return req_ofs(b) + ADDR_W'(4);
  endfunction

  function automatic logic cmd_is_action(input dpd_cmd_e c);
    return (c == CMD_RAIL_ON) || (c == CMD_RAIL_OFF);
  endfunction

  function automatic logic [BANK_W-1:0] apply_cmd(input logic [BANK_W-1:0] cur,
                                                  input dpd_cmd_e c,
                                                  input logic [BANK_W-1:0] sel);
    case (c)
      CMD_RAIL_ON:  return cur & ~sel;
      CMD_RAIL_OFF: return cur | sel;
      default:      return cur;
    endcase
  endfunction
endpackage

// File: rtl/io_dpd_regs.sv
module io_dpd_regs
  import io_dpd_pkg::*;
#(
  parameter int TIM_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  output logic [DATA_W-1:0]     prdata,
  input  logic [N_RAILS-1:0]    stat_flat,
  output logic                  sample_en,
  output logic [TIM_W-1:0]      tim,
  output logic                  req_wr,
  output logic [BANK_IDX_W-1:0] req_bank,
  output logic [DATA_W-1:0]     req_word
);
  logic                wr_acc;
  logic [N_BANKS-1:0]  req_hit;
  logic [N_BANKS-1:0]  stat_hit;
  logic [DATA_W-1:0]   req_q [N_BANKS];

  assign wr_acc   = psel & penable & pwrite;
  assign req_wr   = wr_acc & (|req_hit);
  assign req_word = pwdata;

  always_comb begin
    req_hit  = '0;
    stat_hit = '0;
    req_bank = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      req_hit[b]  = (paddr == req_ofs(b));
      stat_hit[b] = (paddr == stat_ofs(b));
      if (req_hit[b]) req_bank = BANK_IDX_W'(b);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_en <= 1'b0;
      tim       <= '0;
      for (int b = 0; b < N_BANKS; b++) req_q[b] <= '0;
    end else if (wr_acc) begin
      if (paddr == OFS_SAMPLE) sample_en <= pwdata[0];
      if (paddr == OFS_TIMING) tim <= pwdata[TIM_W-1:0];
      for (int b = 0; b < N_BANKS; b++)
        if (req_hit[b]) req_q[b] <= pwdata;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (paddr == OFS_SAMPLE) prdata[0] = sample_en;
      if (paddr == OFS_TIMING) prdata[TIM_W-1:0] = tim;
      for (int b = 0; b < N_BANKS; b++) begin
        if (req_hit[b])  prdata = req_q[b];
        if (stat_hit[b]) prdata = {{(DATA_W-BANK_W){1'b0}}, stat_flat[b*BANK_W +: BANK_W]};
      end
    end
  end
endmodule

// File: rtl/io_dpd_seq.sv
module io_dpd_seq
  import io_dpd_pkg::*;
#(
  parameter int TIM_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_wr,
  input  logic [BANK_IDX_W-1:0] req_bank,
  input  logic [DATA_W-1:0]     req_word,
  input  logic [TIM_W-1:0]      tim,
  output logic                  active,
  output logic                  hold_pend,
  output logic                  done,
  output dpd_req_t              act
);
  dpd_req_t         incoming;
  dpd_req_t         hold_q;
  logic             valid_in;
  logic [TIM_W-1:0] cnt;

  assign incoming.bank = req_bank;
  assign incoming.cmd  = dpd_cmd_e'(req_word[DATA_W-1 -: 2]);
  assign incoming.sel  = req_word[BANK_W-1:0];
  assign valid_in      = req_wr & cmd_is_action(incoming.cmd);
  assign done          = active & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      hold_pend <= 1'b0;
      hold_q    <= '0;
      act       <= '0;
      cnt       <= '0;
    end else if (!active) begin
      if (hold_pend) begin
        active    <= 1'b1;
        act       <= hold_q;
        cnt       <= tim;
        hold_pend <= valid_in;
        if (valid_in) hold_q <= incoming;
      end else if (valid_in) begin
        active <= 1'b1;
        act    <= incoming;
        cnt    <= tim;
      end
    end else begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
      if (valid_in) begin
        hold_q    <= incoming;
        hold_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/io_dpd_rail_bank.sv
module io_dpd_rail_bank
  import io_dpd_pkg::*;
#(
  parameter int BANK_ID = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  apply,
  input  logic [BANK_IDX_W-1:0] act_bank,
  input  dpd_cmd_e              cmd,
  input  logic [BANK_W-1:0]     sel,
  output logic [BANK_W-1:0]     bits
);
  logic apply_here;
  assign apply_here = apply & (act_bank == BANK_IDX_W'(BANK_ID));

  always_ff @(posedge clk) begin
    if (!rst_n)          bits <= '0;
    else if (apply_here) bits <= apply_cmd(bits, cmd, sel);
  end
endmodule

// File: rtl/io_dpd_ctrl.sv
module io_dpd_ctrl
  import io_dpd_pkg::*;
#(
  parameter int TIM_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  output logic [N_RAILS-1:0]   rail_dpd,
  output logic                 busy
);
  logic                  sample_en;
  logic [TIM_W-1:0]      tim;
  logic                  req_wr;
  logic [BANK_IDX_W-1:0] req_bank;
  logic [DATA_W-1:0]     req_word;
  logic                  active;
  logic                  hold_pend;
  logic                  done;
  logic                  apply_en;
  dpd_req_t              act;
  logic [N_RAILS-1:0]    stat_flat;
  logic [N_RAILS-1:0]    act_sel_flat;

  io_dpd_regs #(.TIM_W(TIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .stat_flat(stat_flat),
    .sample_en(sample_en), .tim(tim), .req_wr(req_wr), .req_bank(req_bank),
    .req_word(req_word)
  );

  io_dpd_seq #(.TIM_W(TIM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bank(req_bank),
    .req_word(req_word), .tim(tim), .active(active), .hold_pend(hold_pend),
    .done(done), .act(act)
  );

  assign apply_en = done & sample_en;
  assign busy     = active | hold_pend;
  assign rail_dpd = stat_flat;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    io_dpd_rail_bank #(.BANK_ID(b)) u_bank (
      .clk(clk), .rst_n(rst_n), .apply(apply_en), .act_bank(act.bank),
      .cmd(act.cmd), .sel(act.sel), .bits(stat_flat[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    act_sel_flat = '0;
    act_sel_flat[act.bank*BANK_W +: BANK_W] = act.sel;
  end
endmodule

// File: rtl/io_dpd_ctrl_sva.sv
module io_dpd_ctrl_sva
  import io_dpd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic               sample_en,
  input logic               busy,
  input logic               active,
  input logic               hold_pend,
  input logic               req_wr,
  input logic [DATA_W-1:0]  req_word,
  input dpd_cmd_e           act_cmd,
  input logic [N_RAILS-1:0] act_sel_flat,
  input logic [N_RAILS-1:0] rail_dpd
);
  logic new_is_action;
  assign new_is_action = cmd_is_action(dpd_cmd_e'(req_word[DATA_W-1 -: 2]));

  a_r5_quiet_outside_completion: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rail_dpd));

  a_r6_sampling_off_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sample_en) |=> $stable(rail_dpd));

  a_r2_off_sets_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sample_en && act_cmd == CMD_RAIL_OFF)
      |=> ((rail_dpd & $past(act_sel_flat)) == $past(act_sel_flat)));

  a_r3_on_clears_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sample_en && act_cmd == CMD_RAIL_ON)
      |=> ((rail_dpd & $past(act_sel_flat)) == '0));

  a_r7_only_actions_complete: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (act_cmd == CMD_RAIL_ON || act_cmd == CMD_RAIL_OFF));

  a_r7_inert_code_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !new_is_action && !busy) |=> !busy);

  a_r8_held_starts_next: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pend && !active) |=> active);
endmodule

bind io_dpd_ctrl io_dpd_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .done(done), .sample_en(sample_en), .busy(busy),
  .active(active), .hold_pend(hold_pend), .req_wr(req_wr), .req_word(req_word),
  .act_cmd(act.cmd), .act_sel_flat(act_sel_flat), .rail_dpd(rail_dpd)
);

// File: tb/io_dpd_ctrl_tb.sv
`timescale 1ns/1ps
module io_dpd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [59:0] rail_dpd;
  logic        busy;
  int          n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  io_dpd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rail_dpd(rail_dpd), .busy(busy)
  );

  // {bank, cmd, select mask, expected status word of that bank}
  localparam logic [62:0] VECS [0:7] = '{
    {1'b0, 2'd2, 30'h000000FF, 30'h000000FF},
    {1'b0, 2'd1, 30'h0000000F, 30'h000000F0},
    {1'b1, 2'd2, 30'h20000001, 30'h20000001},
    {1'b0, 2'd3, 30'h3FFFFFFF, 30'h000000F0},
    {1'b0, 2'd0, 30'h00000F00, 30'h000000F0},
    {1'b1, 2'd1, 30'h20000000, 30'h00000001},
    {1'b0, 2'd2, 30'h3FFFFFFF, 30'h3FFFFFFF},
    {1'b0, 2'd1, 30'h15555555, 30'h2AAAAAAA}
  };

  task automatic chk(input string req, input logic [63:0] actual, input logic [63:0] expv);
    n_run++;
    if (actual !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expv);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic bank, input logic [1:0] cmd);
    if (cmd == 2'd0 || cmd == 2'd3) return "R7";
    if (bank) return "R4";
    return (cmd == 2'd2) ? "R2" : "R3";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", 64'(rail_dpd), 64'h0);
    chk("R1", 64'(busy), 64'h0);
    apb_read(12'h020, rd); chk("R1", 64'(rd), 64'h0);
    apb_read(12'h1C8, rd); chk("R1", 64'(rd), 64'h0);
    apb_read(12'h1BC, rd); chk("R1", 64'(rd), 64'h0);
    apb_read(12'h1C4, rd); chk("R1", 64'(rd), 64'h0);

    apb_write(12'h020, 32'h1);
    apb_write(12'h1C8, 32'h3);

    // table walk: R2 R3 R4 R7
    for (int i = 0; i < 8; i++) begin
      logic        bk;
      logic [1:0]  cm;
      logic [29:0] mk, ex;
      {bk, cm, mk, ex} = VECS[i];
      apb_write(bk ? 12'h1C0 : 12'h1B8, {cm, mk});
      wait_idle();
      apb_read(bk ? 12'h1C4 : 12'h1BC, rd);
      chk(tag_of(bk, cm), 64'(rd), 64'({2'b00, ex}));
      chk(tag_of(bk, cm), 64'(bk ? rail_dpd[59:30] : rail_dpd[29:0]), 64'(ex));
    end

    // R5 settle timing, T=3: rail 35 changes on the 4th edge after acceptance
    apb_write(12'h1C0, {2'd2, 30'h20});
    chk("R5", 64'(busy), 64'h1);
    chk("R5", 64'(rail_dpd[35]), 64'h0);
    wait_edges(3);
    chk("R5", 64'(rail_dpd[35]), 64'h0);
    wait_edges(1);
    chk("R5", 64'(rail_dpd[35]), 64'h1);
    chk("R5", 64'(busy), 64'h0);

    // R6 sampling off: completion discards the change
    apb_write(12'h020, 32'h0);
    apb_write(12'h1B8, {2'd1, 30'h3FFFFFFF});
    chk("R6", 64'(busy), 64'h1);
    wait_idle();
    apb_read(12'h1BC, rd); chk("R6", 64'(rd), 64'h2AAAAAAA);
    chk("R6", 64'(rail_dpd[29:0]), 64'h2AAAAAAA);
    apb_write(12'h020, 32'h1);

    // R8 held request
    apb_write(12'h1C0, {2'd2, 30'h400});
    apb_write(12'h1C0, {2'd2, 30'h800});
    wait_edges(2);
    chk("R8", 64'(rail_dpd[40]), 64'h1);
    chk("R8", 64'(rail_dpd[41]), 64'h0);
    chk("R8", 64'(busy), 64'h1);
    wait_idle();
    chk("R8", 64'(rail_dpd[41]), 64'h1);
    apb_read(12'h1C4, rd); chk("R8", 64'(rd), 64'h00000C21);

    // R9 readback
    apb_read(12'h1C8, rd); chk("R9", 64'(rd), 64'h3);
    apb_read(12'h020, rd); chk("R9", 64'(rd), 64'h1);
    apb_read(12'h1C0, rd); chk("R9", 64'(rd), 64'h80000800);
    apb_read(12'h1B8, rd); chk("R9", 64'(rd), 64'h7FFFFFFF);

    // R10 unmapped offsets
    apb_write(12'h000, 32'hFFFFFFFF);
    apb_write(12'h1CC, 32'hFFFFFFFF);
    chk("R10", 64'(busy), 64'h0);
    apb_read(12'h000, rd); chk("R10", 64'(rd), 64'h0);
    apb_read(12'h1CC, rd); chk("R10", 64'(rd), 64'h0);
    chk("R10", 64'(rail_dpd), {4'h0, 30'h00000C21, 30'h2AAAAAAA});
    apb_read(12'h1C8, rd); chk("R10", 64'(rd), 64'h3);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule